// File: doc/BRIEF.md
# Dual Interrupt Output Router

This block sits between two alarm sources and two interrupt pins. It takes a time-of-day alarm flag and a watchdog flag, and a set of command bits that choose which pin carries which source, the active level of the second pin, whether the pins hold a level or fire a timed pulse, and a separate mask for each source. A free-running 1 ms enable times the pulses. When a watchdog pulse completes, the block emits a one-cycle clear strobe so that the watchdog flag logic can drop its flag while its timer keeps running.

Each source has its own small state machine with three states. CH_IDLE waits for work. CH_PULSE holds the source active while it counts tick enables. CH_DONE waits for the unmasked request to fall so that the next rising edge can start a new pulse. The transitions are: IDLE_TO_PULSE on a rising edge of the unmasked flag while pulse mode is selected; PULSE_TO_DONE on the tick that completes the count; PULSE_ABORT back to CH_IDLE if level mode is selected during a pulse; DONE_TO_IDLE once the unmasked request is low. In level mode a source is active for as long as its flag is set and unmasked. The two active signals pass through a swap stage and are registered, and pin B's polarity is then applied.

Top module: `irq_router`

## Requirements
- R1: With swap_i = 1, pin A carries the time-of-day source and pin B the watchdog source. With swap_i = 0, pin A carries the watchdog source and pin B the time-of-day source. A source's active state appears on its pin one clock edge after the cycle in which it becomes active.
- R2: A change of swap_i re-routes the sources at the next clock edge, even while a source is active.
- R3: Pin A is active-low: it is 0 while its source is active and 1 otherwise.
- R4: Pin B is 1 when active and 0 when inactive if b_high_i = 1. It is 0 when active and 1 when inactive if b_high_i = 0. A change of b_high_i takes effect in the same cycle.
- R5: In pulse mode (pulse_mode_i = 1), a rising edge of the unmasked flag sampled at clock edge E0 drives its pin active from edge E0+1. The pin stays active through the third ms_tick_i sampled after E0, and is released one edge after that tick.
- R6: In level mode (pulse_mode_i = 0), the pin follows the unmasked flag one edge later and stays active for as long as the flag remains set.
- R7: wdg_clear_o is high for exactly one cycle, starting at the edge that samples the final tick of a watchdog pulse. A time-of-day pulse or level mode never raises it.
- R8: A mask bit at 1 holds that source's pin inactive in both modes, whatever the flag. A pulse that is already running keeps counting but is not visible while masked.
- R9: One pulse fires per rising edge of the unmasked request. A flag that stays set after its pulse produces no further pulse until it falls and rises again.
- R10: During reset and on the first cycle after it, pin A is 1, pin B is at its inactive level (the inverse of b_high_i) and wdg_clear_o is 0.
- R11: Selecting level mode during a pulse ends the pulse. The pin then follows the flag as in level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_flag_i | input | 1 | Time-of-day alarm flag |
| wdg_flag_i | input | 1 | Watchdog alarm flag |
| swap_i | input | 1 | 1: time-of-day on pin A; 0: watchdog on pin A |
| b_high_i | input | 1 | Pin B active level: 1 high, 0 low |
| pulse_mode_i | input | 1 | 1: timed pulse; 0: held level |
| tod_mask_i | input | 1 | Masks the time-of-day source |
| wdg_mask_i | input | 1 | Masks the watchdog source |
| ms_tick_i | input | 1 | One-cycle 1 ms enable |
| pin_a_n_o | output | 1 | Interrupt pin A, active-low |
| pin_b_o | output | 1 | Interrupt pin B, programmable polarity |
| wdg_clear_o | output | 1 | One-cycle strobe that clears the watchdog flag after its pulse |

## Verification
The hardest situations to reach from the ports are command changes that land while a pulse is in flight: a swap, a mask or a switch to level mode arriving between the first and third tick, and a flag that stays high across the end of its pulse. Directed sequences place each of these at a known tick count. A seeded random phase then toggles the command bits rarely and the flags and tick often, so that many pulses overlap command changes. A cycle-level reference model in the bench scores every cycle of that phase.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_PULSE = 2'd1,
        CH_DONE  = 2'd2
    } chan_state_e;

    localparam int SRC_TOD = 0;
    localparam int SRC_WDG = 1;
    localparam int NUM_SRC = 2;

endpackage

// File: rtl/irq_pulse_chan.sv
module irq_pulse_chan
    import irq_router_pkg::*;
#(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic mask_i,
    input  logic pulse_mode_i,
    input  logic tick_i,
    output logic active_o,
    output logic pulse_end_o
);

    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(PULSE_TICKS - 1);

    chan_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic req, req_q, req_rise;

    assign req      = flag_i & ~mask_i;
    assign req_rise = req & ~req_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            req_q   <= req;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_IDLE: begin
                if (pulse_mode_i && req_rise) begin
                    state_d = CH_PULSE;
                    cnt_d   = '0;
                end
            end
            CH_PULSE: begin
                if (!pulse_mode_i) begin
                    state_d = CH_IDLE;
                end else if (tick_i) begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = CH_DONE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CH_DONE: begin
                if (!req) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        if (pulse_mode_i) begin
            active_o = (state_q == CH_PULSE) && !mask_i;
        end else begin
            active_o = req;
        end
        pulse_end_o = (state_q == CH_PULSE) && pulse_mode_i && tick_i
                      && (cnt_q == LAST_CNT);
    end

endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_i,
    input  logic b_high_i,
    input  logic tod_act_i,
    input  logic wdg_act_i,
    input  logic wdg_end_i,
    output logic pin_a_n_o,
    output logic pin_b_o,
    output logic wdg_clear_o
);

    logic a_act_q, b_act_q, clr_q;
    logic a_sel, b_sel;

    always_comb begin
        a_sel = swap_i ? tod_act_i : wdg_act_i;
        b_sel = swap_i ? wdg_act_i : tod_act_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_act_q <= 1'b0;
            b_act_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            a_act_q <= a_sel;
            b_act_q <= b_sel;
            clr_q   <= wdg_end_i;
        end
    end

    assign pin_a_n_o   = ~a_act_q;
    assign pin_b_o     = b_act_q ^ ~b_high_i;
    assign wdg_clear_o = clr_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tod_flag_i,
    input  logic wdg_flag_i,
    input  logic swap_i,
    input  logic b_high_i,
    input  logic pulse_mode_i,
    input  logic tod_mask_i,
    input  logic wdg_mask_i,
    input  logic ms_tick_i,
    output logic pin_a_n_o,
    output logic pin_b_o,
    output logic wdg_clear_o
);

    logic [NUM_SRC-1:0] src_flag, src_mask, src_act, src_end;

    assign src_flag = {wdg_flag_i, tod_flag_i};
    assign src_mask = {wdg_mask_i, tod_mask_i};

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_chan
            irq_pulse_chan #(
                .PULSE_TICKS (PULSE_TICKS)
            ) u_chan (
                .clk          (clk),
                .rst_n        (rst_n),
                .flag_i       (src_flag[s]),
                .mask_i       (src_mask[s]),
                .pulse_mode_i (pulse_mode_i),
                .tick_i       (ms_tick_i),
                .active_o     (src_act[s]),
                .pulse_end_o  (src_end[s])
            );
        end
    endgenerate

    irq_pin_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap_i      (swap_i),
        .b_high_i    (b_high_i),
        .tod_act_i   (src_act[SRC_TOD]),
        .wdg_act_i   (src_act[SRC_WDG]),
        .wdg_end_i   (src_end[SRC_WDG]),
        .pin_a_n_o   (pin_a_n_o),
        .pin_b_o     (pin_b_o),
        .wdg_clear_o (wdg_clear_o)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
    input logic clk,
    input logic rst_n,
    input logic tod_flag_i,
    input logic wdg_flag_i,
    input logic swap_i,
    input logic b_high_i,
    input logic pulse_mode_i,
    input logic tod_mask_i,
    input logic wdg_mask_i,
    input logic pin_a_n_o,
    input logic pin_b_o,
    input logic wdg_clear_o
);

    // R7: the clear strobe lasts a single cycle
    p_clear_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_clear_o |=> !wdg_clear_o);

    // R7: the clear strobe only follows a cycle spent in pulse mode
    p_clear_pulse_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_clear_o |-> $past(pulse_mode_i));

    // R8: both sources masked leaves both pins inactive at the next edge
    p_masked_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_mask_i && wdg_mask_i) |=> (pin_a_n_o && (pin_b_o != b_high_i)));

    // R6: level mode, time-of-day on pin A, flag set and unmasked
    p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode_i && swap_i && tod_flag_i && !tod_mask_i) |=> !pin_a_n_o);

    // R1: level mode, watchdog on pin A when not swapped
    p_route_wdg_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode_i && !swap_i && wdg_flag_i && !wdg_mask_i) |=> !pin_a_n_o);

    // R10: first cycle after reset shows inactive pins
    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_a_n_o && (pin_b_o != b_high_i) && !wdg_clear_o));

endmodule

bind irq_router irq_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tod_flag_i   (tod_flag_i),
    .wdg_flag_i   (wdg_flag_i),
    .swap_i       (swap_i),
    .b_high_i     (b_high_i),
    .pulse_mode_i (pulse_mode_i),
    .tod_mask_i   (tod_mask_i),
    .wdg_mask_i   (wdg_mask_i),
    .pin_a_n_o    (pin_a_n_o),
    .pin_b_o      (pin_b_o),
    .wdg_clear_o  (wdg_clear_o)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tod_flag = 0, wdg_flag = 0, swap = 0, b_high = 1, pmode = 0;
    logic tod_mask = 0, wdg_mask = 0, tick = 0;
    logic pin_a_n, pin_b, wdg_clear;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit mon_en = 0;

    always #5 clk = ~clk;

    irq_router uut (
        .clk (clk), .rst_n (rst_n),
        .tod_flag_i (tod_flag), .wdg_flag_i (wdg_flag),
        .swap_i (swap), .b_high_i (b_high), .pulse_mode_i (pmode),
        .tod_mask_i (tod_mask), .wdg_mask_i (wdg_mask), .ms_tick_i (tick),
        .pin_a_n_o (pin_a_n), .pin_b_o (pin_b), .wdg_clear_o (wdg_clear)
    );

    // reference model: per source 0 = time-of-day, 1 = watchdog
    int m_st [2];   // 0 waiting, 1 pulsing, 2 spent
    int m_cnt [2];
    bit m_rq [2];
    bit m_aa, m_ba, m_clr;

    function automatic bit src_act(int s, bit f, bit m);
        if (pmode) return (m_st[s] == 1) && !m;
        return f && !m;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_st[s] <= 0; m_cnt[s] <= 0; m_rq[s] <= 0;
            end
            m_aa <= 0; m_ba <= 0; m_clr <= 0;
        end else begin
            bit f [2];
            bit m [2];
            bit act [2];
            bit fin [2];
            f[0] = tod_flag; f[1] = wdg_flag;
            m[0] = tod_mask; m[1] = wdg_mask;
            for (int s = 0; s < 2; s++) begin
                bit rq;
                rq = f[s] && !m[s];
                act[s] = src_act(s, f[s], m[s]);
                fin[s] = (m_st[s] == 1) && pmode && tick && (m_cnt[s] == 2);
                m_rq[s] <= rq;
                case (m_st[s])
                    0: if (pmode && rq && !m_rq[s]) begin m_st[s] <= 1; m_cnt[s] <= 0; end
                    1: if (!pmode) m_st[s] <= 0;
                       else if (tick) begin
                           if (m_cnt[s] == 2) m_st[s] <= 2;
                           else m_cnt[s] <= m_cnt[s] + 1;
                       end
                    default: if (!rq) m_st[s] <= 0;
                endcase
            end
            m_aa  <= swap ? act[0] : act[1];
            m_ba  <= swap ? act[1] : act[0];
            m_clr <= fin[1];
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // per-cycle scoring against the model
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            chk("R1", "pin A vs model", pin_a_n, !m_aa);
            chk("R4", "pin B vs model", pin_b, m_ba ? b_high : !b_high);
            chk("R7", "clear vs model", wdg_clear, m_clr);
        end
    end

    task automatic adv(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1; adv(); tick = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        adv(3);
        look();
        chk("R10", "pin A in reset", pin_a_n, 1'b1);
        chk("R10", "pin B in reset", pin_b, !b_high);
        chk("R10", "clear in reset", wdg_clear, 1'b0);
        adv(); rst_n = 1; mon_en = 1;
        look();
        chk("R10", "pin A after reset", pin_a_n, 1'b1);
        chk("R10", "pin B after reset", pin_b, 1'b0);

        // level mode, time-of-day routed to A
        adv(); pmode = 0; swap = 1; tod_flag = 1;
        adv(); look();
        chk("R3", "pin A active-low", pin_a_n, 1'b0);
        chk("R1", "pin B idle while wdg quiet", pin_b, 1'b0);
        // live swap while active
        adv(); swap = 0;
        adv(); look();
        chk("R2", "pin A released after swap", pin_a_n, 1'b1);
        chk("R2", "pin B active after swap", pin_b, 1'b1);
        // polarity change is immediate
        adv(); b_high = 0; look();
        chk("R4", "pin B active-low", pin_b, 1'b0);
        adv(); tod_mask = 1;
        adv(); look();
        chk("R8", "masked pin B inactive", pin_b, 1'b1);
        adv(); tod_flag = 0; tod_mask = 0; b_high = 1;

        // level hold: watchdog on A, stays while flag set despite ticks
        adv(); wdg_flag = 1;
        adv(); look();
        chk("R6", "level asserts", pin_a_n, 1'b0);
        for (int k = 0; k < 5; k++) begin adv(3); pulse_tick(); end
        look();
        chk("R6", "level held", pin_a_n, 1'b0);
        adv(); wdg_flag = 0;
        adv(); look();
        chk("R6", "level releases", pin_a_n, 1'b1);

        // pulse mode on watchdog (pin A)
        adv(); pmode = 1;
        adv(); wdg_flag = 1;
        adv(2); look();
        chk("R5", "pulse asserts", pin_a_n, 1'b0);
        for (int k = 0; k < 3; k++) begin
            adv(8); look();
            chk("R5", "pulse held before tick", pin_a_n, 1'b0);
            adv(); tick = 1;
            if (k == 2) begin
                adv(); tick = 0; look();
                chk("R7", "clear at final tick", wdg_clear, 1'b1);
                chk("R5", "still active at final tick", pin_a_n, 1'b0);
            end else begin
                adv(); tick = 0;
            end
        end
        adv(); look();
        chk("R5", "pulse released", pin_a_n, 1'b1);
        chk("R7", "clear single cycle", wdg_clear, 1'b0);
        for (int k = 0; k < 4; k++) begin adv(3); pulse_tick(); end
        look();
        chk("R9", "no repeat while flag held", pin_a_n, 1'b1);
        adv(); wdg_flag = 0;
        adv(); wdg_flag = 1;
        adv(2); look();
        chk("R9", "new edge new pulse", pin_a_n, 1'b0);
        // abort to level mode mid-pulse, then flag drop
        adv(); pulse_tick();
        pmode = 0; wdg_flag = 0;
        adv(); look();
        chk("R11", "level mode ends pulse", pin_a_n, 1'b1);

        // time-of-day pulse on B must not raise clear
        adv(); pmode = 1; tod_flag = 1;
        for (int k = 0; k < 3; k++) begin adv(2); pulse_tick(); end
        look();
        chk("R7", "no clear for tod pulse", wdg_clear, 1'b0);
        adv(); tod_flag = 0;

        // constrained random phase, scored by the model
        for (int i = 0; i < 4000; i++) begin
            adv();
            if (wdg_clear) wdg_flag = 0;
            else if ($urandom_range(7) == 0) wdg_flag = ~wdg_flag;
            if ($urandom_range(7) == 0) tod_flag = ~tod_flag;
            if ($urandom_range(39) == 0) tod_mask = ~tod_mask;
            if ($urandom_range(39) == 0) wdg_mask = ~wdg_mask;
            if ($urandom_range(29) == 0) swap = ~swap;
            if ($urandom_range(24) == 0) b_high = ~b_high;
            if ($urandom_range(59) == 0) pmode = ~pmode;
            tick = ($urandom_range(3) == 0);
        end
        adv(2);
        finish_run();
    end

endmodule